// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two binary32 operands and delivers a binary32 sum together with four exception flags. The result is registered once: operands, rounding mode and flush control present at one rising clock edge determine the sum and flags visible after that edge. There is no handshake. A new pair may be issued on every cycle.

Each operand is first sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. When either class is special, a selector picks the result from the class pair. Otherwise the arithmetic path runs. It extends both significands with guard, round and sticky positions and aligns the smaller operand with a sticky right shift. It then adds or subtracts the magnitudes, normalizes the result and rounds it under the requested mode. When the flush control is high, subnormal inputs count as zeros of their own sign.

Top module: `fp32_adder`

## Requirements
- R1: The sum and flags are registered outputs that reflect the inputs sampled at the previous rising edge. A synchronous active-high reset clears the sum to 0x00000000 and all flags to 0.
- R2: A signalling NaN is an all-ones exponent with fraction bit 22 clear and a nonzero fraction. If x is signalling, the result is x with bit 22 set and invalid raised. Otherwise, if y is signalling, the result is y with bit 22 set and invalid raised, even when x is a quiet NaN.
- R3: A quiet NaN has an all-ones exponent with fraction bit 22 set. With no signalling NaN present, a quiet NaN x is returned unchanged. Failing that, a quiet NaN y is returned unchanged. No flag is raised in either case.
- R4: Two infinities of the same sign return that infinity. An infinity plus any finite value returns the infinity.
- R5: A zero plus a nonzero finite value returns the nonzero operand unchanged. Two zeros of the same sign return that zero. Opposite-signed zeros, and an exact cancellation of finite values, return +0, except -0 when the rounding mode is toward minus infinity. None of these cases raises a flag.
- R6: A finite sum is correctly rounded under the 2-bit mode input: 00 nearest-even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity. Inexact is raised exactly when the delivered result differs from the exact sum.
- R7: When the rounded magnitude exceeds the largest finite value, overflow and inexact are raised. The result is infinity under nearest-even, the largest finite value under toward-zero, and for the directed modes infinity only when rounding away from zero.
- R8: With flush low, subnormal inputs contribute their exact value. With flush high, subnormal inputs act as zeros of their own sign, so a subnormal plus a normal value returns the normal operand unchanged.
- R9: Underflow is raised only for a tiny result that is also inexact. Exact subnormal sums leave underflow clear.
- R10: Invalid is raised only for a signalling NaN operand or for infinities of opposite sign. In the second case the result is the default quiet NaN 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 32 | First binary32 operand |
| y_i | input | 32 | Second binary32 operand |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| flush_i | input | 1 | When high, subnormal inputs are read as signed zeros |
| sum_o | output | 32 | Registered binary32 sum |
| invalid_o | output | 1 | Registered invalid-operation flag |
| overflow_o | output | 1 | Registered overflow flag |
| underflow_o | output | 1 | Registered underflow flag |
| inexact_o | output | 1 | Registered inexact flag |

## Verification
Every result and flag is due exactly one rising edge after its operands are presented. This holds for NaN propagation, for special-class selection and for the rounded arithmetic path alike. The bench drives each operand pair on a falling edge and compares the outputs on the next falling edge against a behavioural model that computes the exact sum as a wide integer. The checker uses one-cycle implications for the same reason. A reset applied mid-run is expected to clear the outputs one edge later.

// File: rtl/fp32_add_pkg.sv
package fp32_add_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int EXT_W   = SIG_W + 3;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int IEXP_W  = EXP_W + 2;
    localparam int LZ_W    = $clog2(EXT_W + 1);
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] QUIET_MASK =
        {{(1+EXP_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fclass_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              sign;
        logic [IEXP_W-1:0] exp;
        logic [SIG_W-1:0]  sig;
        fclass_e           cls;
    } operand_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] cnt;
        logic            seen;
        cnt  = '0;
        seen = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      cnt  = cnt + 1'b1;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/fp32_unpack.sv
module fp32_unpack
    import fp32_add_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              flush_i,
    output operand_t          op_o
);
    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;

    assign e_fld = word_i[WORD_W-2:FRAC_W];
    assign f_fld = word_i[FRAC_W-1:0];

    always_comb begin
        op_o.sign = word_i[WORD_W-1];
        op_o.exp  = IEXP_W'(1);
        op_o.sig  = '0;
        op_o.cls  = CL_ZERO;
        if (e_fld == '0) begin
            if (f_fld != '0 && !flush_i) begin
                op_o.cls = CL_SUB;
                op_o.sig = {1'b0, f_fld};
            end
        end else if (e_fld == {EXP_W{1'b1}}) begin
            op_o.exp = IEXP_W'(EXP_MAX);
            if (f_fld == '0)          op_o.cls = CL_INF;
            else if (f_fld[FRAC_W-1]) op_o.cls = CL_QNAN;
            else                      op_o.cls = CL_SNAN;
        end else begin
            op_o.cls = CL_NORM;
            op_o.exp = IEXP_W'(e_fld);
            op_o.sig = {1'b1, f_fld};
        end
    end
endmodule

// File: rtl/fp32_special.sv
module fp32_special
    import fp32_add_pkg::*;
(
    input  logic [WORD_W-1:0] x_word_i,
    input  logic [WORD_W-1:0] y_word_i,
    input  fclass_e           x_cls_i,
    input  fclass_e           y_cls_i,
    input  logic              x_sign_i,
    input  logic              y_sign_i,
    input  rmode_e            rmode_i,
    output logic              take_o,
    output logic [WORD_W-1:0] word_o,
    output flags_t            flags_o
);
    always_comb begin
        take_o  = 1'b1;
        word_o  = '0;
        flags_o = '0;
        if (x_cls_i == CL_SNAN) begin
            word_o          = x_word_i | QUIET_MASK;
            flags_o.invalid = 1'b1;
        end else if (y_cls_i == CL_SNAN) begin
            word_o          = y_word_i | QUIET_MASK;
            flags_o.invalid = 1'b1;
        end else if (x_cls_i == CL_QNAN) begin
            word_o = x_word_i;
        end else if (y_cls_i == CL_QNAN) begin
            word_o = y_word_i;
        end else if (x_cls_i == CL_INF && y_cls_i == CL_INF) begin
            if (x_sign_i == y_sign_i) begin
                word_o = x_word_i;
            end else begin
                word_o          = DEFAULT_NAN;
                flags_o.invalid = 1'b1;
            end
        end else if (x_cls_i == CL_INF) begin
            word_o = x_word_i;
        end else if (y_cls_i == CL_INF) begin
            word_o = y_word_i;
        end else if (x_cls_i == CL_ZERO && y_cls_i == CL_ZERO) begin
            if (x_sign_i == y_sign_i) word_o = {x_sign_i, {(WORD_W-1){1'b0}}};
            else                      word_o = {rmode_i == RM_DOWN, {(WORD_W-1){1'b0}}};
        end else if (x_cls_i == CL_ZERO) begin
            word_o = y_word_i;
        end else if (y_cls_i == CL_ZERO) begin
            word_o = x_word_i;
        end else begin
            take_o = 1'b0;
        end
    end
endmodule

// File: rtl/fp32_sticky_shift.sv
module fp32_sticky_shift #(
    parameter int W    = 27,
    parameter int SH_W = 10
) (
    input  logic [W-1:0]    val_i,
    input  logic [SH_W-1:0] amt_i,
    output logic [W-1:0]    val_o
);
    logic         lost;
    logic [W-1:0] moved;

    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (SH_W'(i) < amt_i) lost = lost | val_i[i];
        end
        moved = (amt_i >= SH_W'(W)) ? '0 : (val_i >> amt_i);
        val_o = {moved[W-1:1], moved[0] | lost};
    end
endmodule

// File: rtl/fp32_core.sv
module fp32_core
    import fp32_add_pkg::*;
(
    input  logic              a_sign_i,
    input  logic [IEXP_W-1:0] a_exp_i,
    input  logic [SIG_W-1:0]  a_sig_i,
    input  logic              b_sign_i,
    input  logic [IEXP_W-1:0] b_exp_i,
    input  logic [SIG_W-1:0]  b_sig_i,
    input  rmode_e            rmode_i,
    output logic [WORD_W-1:0] word_o,
    output flags_t            flags_o
);
    logic              a_big;
    logic              big_sign, sml_sign;
    logic [IEXP_W-1:0] big_exp, sml_exp, gap;
    logic [EXT_W-1:0]  big_m, sml_m, sml_al;
    logic [EXT_W:0]    sum_w;
    logic [EXT_W-1:0]  dif_w;
    logic [LZ_W-1:0]   lz;
    logic [IEXP_W-1:0] lz_ext, room, lsh;
    logic [EXT_W-1:0]  m_n;
    logic [IEXP_W-1:0] e_n;
    logic              cancel, rest, inc, to_inf, ovf;
    logic [SIG_W:0]    rnd;
    logic [IEXP_W-1:0] e_fin;
    logic [FRAC_W-1:0] frac_fin;

    assign a_big    = {a_exp_i, a_sig_i} >= {b_exp_i, b_sig_i};
    assign big_sign = a_big ? a_sign_i : b_sign_i;
    assign sml_sign = a_big ? b_sign_i : a_sign_i;
    assign big_exp  = a_big ? a_exp_i  : b_exp_i;
    assign sml_exp  = a_big ? b_exp_i  : a_exp_i;
    assign big_m    = {(a_big ? a_sig_i : b_sig_i), 3'b000};
    assign sml_m    = {(a_big ? b_sig_i : a_sig_i), 3'b000};
    assign gap      = big_exp - sml_exp;

    fp32_sticky_shift #(.W(EXT_W), .SH_W(IEXP_W)) u_align (
        .val_i (sml_m),
        .amt_i (gap),
        .val_o (sml_al)
    );

    assign sum_w  = {1'b0, big_m} + {1'b0, sml_al};
    assign dif_w  = big_m - sml_al;
    assign lz     = lead_zeros(dif_w);
    assign lz_ext = IEXP_W'(lz);
    assign room   = big_exp - IEXP_W'(1);
    assign lsh    = (lz_ext > room) ? room : lz_ext;

    always_comb begin
        cancel = 1'b0;
        if (big_sign == sml_sign) begin
            if (sum_w[EXT_W]) begin
                m_n = {sum_w[EXT_W:2], |sum_w[1:0]};
                e_n = big_exp + IEXP_W'(1);
            end else begin
                m_n = sum_w[EXT_W-1:0];
                e_n = big_exp;
            end
        end else begin
            cancel = (dif_w == '0);
            m_n    = dif_w << lsh;
            e_n    = big_exp - lsh;
        end
    end

    assign rest = |m_n[2:0];

    always_comb begin
        unique case (rmode_i)
            RM_NEAR: inc = m_n[2] & (m_n[1] | m_n[0] | m_n[3]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = rest & ~big_sign;
            default: inc = rest & big_sign;
        endcase
    end

    assign rnd = {1'b0, m_n[EXT_W-1:3]} + (SIG_W+1)'(inc);

    always_comb begin
        if (rnd[SIG_W]) begin
            frac_fin = '0;
            e_fin    = e_n + IEXP_W'(1);
        end else begin
            frac_fin = rnd[FRAC_W-1:0];
            e_fin    = rnd[SIG_W-1] ? e_n : '0;
        end
    end

    assign ovf    = e_fin >= IEXP_W'(EXP_MAX);
    assign to_inf = (rmode_i == RM_NEAR) ||
                    (rmode_i == RM_UP && !big_sign) ||
                    (rmode_i == RM_DOWN && big_sign);

    always_comb begin
        flags_o = '0;
        if (cancel) begin
            word_o = {rmode_i == RM_DOWN, {(WORD_W-1){1'b0}}};
        end else if (ovf) begin
            flags_o.overflow = 1'b1;
            flags_o.inexact  = 1'b1;
            word_o = to_inf ? {big_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                            : {big_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
            flags_o.inexact   = rest;
            flags_o.underflow = rest & ~m_n[EXT_W-1];
            word_o = {big_sign, e_fin[EXP_W-1:0], frac_fin};
        end
    end
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
    import fp32_add_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] x_i,
    input  logic [31:0] y_i,
    input  logic [1:0]  rmode_i,
    input  logic        flush_i,
    output logic [31:0] sum_o,
    output logic        invalid_o,
    output logic        overflow_o,
    output logic        underflow_o,
    output logic        inexact_o
);
    operand_t          op_x, op_y;
    rmode_e            rm;
    logic              spc_take;
    logic [WORD_W-1:0] spc_word, core_word, sum_q;
    flags_t            spc_flags, core_flags, flags_q;

    assign rm = rmode_e'(rmode_i);

    fp32_unpack u_unp_x (.word_i(x_i), .flush_i(flush_i), .op_o(op_x));
    fp32_unpack u_unp_y (.word_i(y_i), .flush_i(flush_i), .op_o(op_y));

    fp32_special u_spc (
        .x_word_i (x_i),
        .y_word_i (y_i),
        .x_cls_i  (op_x.cls),
        .y_cls_i  (op_y.cls),
        .x_sign_i (op_x.sign),
        .y_sign_i (op_y.sign),
        .rmode_i  (rm),
        .take_o   (spc_take),
        .word_o   (spc_word),
        .flags_o  (spc_flags)
    );

    fp32_core u_core (
        .a_sign_i (op_x.sign),
        .a_exp_i  (op_x.exp),
        .a_sig_i  (op_x.sig),
        .b_sign_i (op_y.sign),
        .b_exp_i  (op_y.exp),
        .b_sig_i  (op_y.sig),
        .rmode_i  (rm),
        .word_o   (core_word),
        .flags_o  (core_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            flags_q <= '0;
        end else begin
            sum_q   <= spc_take ? spc_word  : core_word;
            flags_q <= spc_take ? spc_flags : core_flags;
        end
    end

    assign sum_o       = sum_q;
    assign invalid_o   = flags_q.invalid;
    assign overflow_o  = flags_q.overflow;
    assign underflow_o = flags_q.underflow;
    assign inexact_o   = flags_q.inexact;
endmodule

// File: rtl/fp32_adder_chk.sv
module fp32_adder_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] x_i,
    input logic [31:0] y_i,
    input logic [31:0] sum_o,
    input logic        invalid_o,
    input logic        overflow_o,
    input logic        underflow_o,
    input logic        inexact_o
);
    logic x_snan, y_snan, x_qnan, x_inf, y_inf, out_nan;

    assign x_snan  = (x_i[30:23] == 8'hFF) && !x_i[22] && (x_i[21:0] != '0);
    assign y_snan  = (y_i[30:23] == 8'hFF) && !y_i[22] && (y_i[21:0] != '0);
    assign x_qnan  = (x_i[30:23] == 8'hFF) && x_i[22];
    assign x_inf   = (x_i[30:0] == 31'h7F800000);
    assign y_inf   = (y_i[30:0] == 31'h7F800000);
    assign out_nan = (sum_o[30:23] == 8'hFF) && (sum_o[22:0] != '0);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sum_o == 32'h0 && !invalid_o && !overflow_o && !underflow_o && !inexact_o));

    // R2
    a_r2_x_snan_quieted: assert property (@(posedge clk) disable iff (rst)
        x_snan |=> (invalid_o && sum_o == ($past(x_i) | 32'h00400000)));

    // R3
    a_r3_x_qnan_passes: assert property (@(posedge clk) disable iff (rst)
        (x_qnan && !y_snan) |=> (sum_o == $past(x_i) && !invalid_o));

    // R4
    a_r4_same_sign_inf: assert property (@(posedge clk) disable iff (rst)
        (x_inf && y_inf && x_i[31] == y_i[31]) |=> (sum_o == $past(x_i)));

    // R10
    a_r10_opposite_inf_invalid: assert property (@(posedge clk) disable iff (rst)
        (x_inf && y_inf && x_i[31] != y_i[31]) |=> (invalid_o && sum_o == 32'h7FC00000));

    // R10
    a_r10_invalid_gives_nan: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> out_nan);

    // R7
    a_r7_overflow_inexact: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (inexact_o && !underflow_o));

    // R9
    a_r9_underflow_needs_inexact: assert property (@(posedge clk) disable iff (rst)
        underflow_o |-> inexact_o);
endmodule

bind fp32_adder fp32_adder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .x_i         (x_i),
    .y_i         (y_i),
    .sum_o       (sum_o),
    .invalid_o   (invalid_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .inexact_o   (inexact_o)
);

// File: tb/fp32_adder_bench.sv
`timescale 1ns/1ps
module fp32_adder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] x_i = '0, y_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        flush_i = 1'b0;
    logic [31:0] sum_o;
    logic        invalid_o, overflow_o, underflow_o, inexact_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    bit    have_pend = 1'b0;
    logic [35:0] pend_exp;
    string pend_tag;

    always #2 clk = ~clk;

    fp32_adder u_fp32_adder (
        .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i), .rmode_i(rmode_i),
        .flush_i(flush_i), .sum_o(sum_o), .invalid_o(invalid_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o), .inexact_o(inexact_o)
    );

    // Exact value in units of 2^-149
    function automatic logic [279:0] mag_of(input logic [7:0] e, input logic [22:0] f);
        if (e == 8'h00) return {257'b0, f};
        return {256'b0, 1'b1, f} << (e - 1);
    endfunction

    // Reference: {invalid, overflow, underflow, inexact, result}
    function automatic logic [35:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                            input logic [1:0] rm, input logic fl);
        logic [279:0] mx, my, mm, rem, half, one;
        logic [24:0]  q;
        logic         s, xz, yz, xi, yi, xq, yq, xsn, ysn, up;
        int           p, sh, e;
        one = 280'd1;
        xz  = (x[30:23] == 0) && (x[22:0] == 0 || fl);
        yz  = (y[30:23] == 0) && (y[22:0] == 0 || fl);
        xi  = (x[30:0] == 31'h7F800000);
        yi  = (y[30:0] == 31'h7F800000);
        xq  = (x[30:23] == 8'hFF) && x[22];
        yq  = (y[30:23] == 8'hFF) && y[22];
        xsn = (x[30:23] == 8'hFF) && !x[22] && x[21:0] != 0;
        ysn = (y[30:23] == 8'hFF) && !y[22] && y[21:0] != 0;
        if (xsn) return {4'b1000, x | 32'h00400000};
        if (ysn) return {4'b1000, y | 32'h00400000};
        if (xq) return {4'b0000, x};
        if (yq) return {4'b0000, y};
        if (xi && yi) return (x[31] == y[31]) ? {4'b0000, x} : {4'b1000, 32'h7FC00000};
        if (xi) return {4'b0000, x};
        if (yi) return {4'b0000, y};
        if (xz && yz) return (x[31] == y[31]) ? {4'b0000, x[31], 31'b0}
                                              : {4'b0000, rm == 2'b11, 31'b0};
        if (xz) return {4'b0000, y};
        if (yz) return {4'b0000, x};
        mx = mag_of(x[30:23], x[22:0]);
        my = mag_of(y[30:23], y[22:0]);
        if (x[31] == y[31]) begin mm = mx + my; s = x[31]; end
        else if (mx >= my)  begin mm = mx - my; s = x[31]; end
        else                begin mm = my - mx; s = y[31]; end
        if (mm == 0) return {4'b0000, rm == 2'b11, 31'b0};
        p = 0;
        for (int i = 0; i < 280; i++) if (mm[i]) p = i;
        if (p <= 23) return {4'b0000, s, mm[30:0]};
        sh   = p - 23;
        q    = 25'(mm >> sh);
        rem  = mm & ((one << sh) - one);
        half = one << (sh - 1);
        case (rm)
            2'b00:   up = (rem > half) || (rem == half && q[0]);
            2'b01:   up = 1'b0;
            2'b10:   up = (rem != 0) && !s;
            default: up = (rem != 0) && s;
        endcase
        q = q + 25'(up);
        e = sh + 1;
        if (q[24]) begin q = q >> 1; e = e + 1; end
        if (e >= 255) begin
            if (rm == 2'b00 || (rm == 2'b10 && !s) || (rm == 2'b11 && s))
                return {4'b0101, s, 8'hFF, 23'h0};
            return {4'b0101, s, 8'hFE, 23'h7FFFFF};
        end
        return {3'b000, rem != 0, s, 8'(e), q[22:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] x, input logic [31:0] y,
                                     input logic fl, input logic [35:0] ex);
        bit xn, yn, xs, ys;
        xn = x[30:23] == 8'hFF && x[22:0] != 0;
        yn = y[30:23] == 8'hFF && y[22:0] != 0;
        xs = xn && !x[22];
        ys = yn && !y[22];
        if (xs || ys) return "R2";
        if (xn || yn) return "R3";
        if (x[30:23] == 8'hFF || y[30:23] == 8'hFF) return ex[35] ? "R10" : "R4";
        if (ex[34]) return "R7";
        if ((x[30:23] == 0 && x[22:0] != 0) || (y[30:23] == 0 && y[22:0] != 0))
            return fl ? "R8" : "R9";
        if (x[30:0] == 0 || y[30:0] == 0 || ex[30:0] == 0) return "R5";
        return "R6";
    endfunction

    task automatic compare_pending;
        logic [35:0] act;
        if (have_pend) begin
            act = {invalid_o, overflow_o, underflow_o, inexact_o, sum_o};
            n_cmp++;
            if (act !== pend_exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h flags=%b expected=%h flags=%b",
                         pend_tag, act[31:0], act[35:32], pend_exp[31:0], pend_exp[35:32]);
            end
        end
        have_pend = 1'b0;
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] y,
                         input logic [1:0] rm, input logic fl, input string tag);
        @(negedge clk);
        compare_pending();
        x_i = x; y_i = y; rmode_i = rm; flush_i = fl;
        pend_exp  = ref_add(x, y, rm, fl);
        pend_tag  = (tag == "") ? tag_of(x, y, fl, pend_exp) : tag;
        have_pend = 1'b1;
    endtask

    function automatic logic [31:0] pick(input int kind, input logic [31:0] other);
        logic [31:0] r;
        logic        sg;
        r  = $urandom;
        sg = r[31];
        case (kind)
            3:       return {sg, 31'h0};
            4:       return {sg, 8'hFF, 23'h0};
            5:       return {sg, 8'hFF, 1'b1, r[21:0]};
            6:       return {sg, 8'hFF, 1'b0, r[21:1], 1'b1};
            7:       return {sg, 8'h00, r[22:0]};
            8:       return other ^ 32'h80000000 ^ (r & 32'h0000001F);
            9:       return {sg, 7'h7F, r[23], r[22:0]};
            default: return r;
        endcase
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        pend_exp = '0; pend_tag = "R1 reset"; have_pend = 1'b1;
        compare_pending();
        rst = 1'b0;

        apply(32'h3F800000, 32'h3F800000, 2'b00, 1'b0, "R6 one plus one");
        apply(32'h3F800000, 32'h33800000, 2'b00, 1'b0, "R6 tie to even");
        apply(32'h3F800000, 32'h33800000, 2'b10, 1'b0, "R6 round up");
        apply(32'h3F800001, 32'hBF800000, 2'b00, 1'b0, "R6 cancel renorm");
        apply(32'h3F800000, 32'hBF800000, 2'b00, 1'b0, "R5 exact cancel");
        apply(32'h3F800000, 32'hBF800000, 2'b11, 1'b0, "R5 cancel toward minus");
        apply(32'h00000000, 32'h80000000, 2'b00, 1'b0, "R5 opposite zeros");
        apply(32'h00000000, 32'h80000000, 2'b11, 1'b0, "R5 opposite zeros down");
        apply(32'h80000000, 32'h80000000, 2'b00, 1'b0, "R5 same zeros");
        apply(32'h00000000, 32'h40490FDB, 2'b01, 1'b0, "R5 zero plus value");
        apply(32'h7FC00001, 32'h7F800005, 2'b00, 1'b0, "R2 y signalling beats x quiet");
        apply(32'hFF800001, 32'h7FC00000, 2'b00, 1'b0, "R2 x signalling");
        apply(32'h7FC12345, 32'h3F800000, 2'b00, 1'b0, "R3 x quiet");
        apply(32'h3F800000, 32'hFFC12345, 2'b00, 1'b0, "R3 y quiet");
        apply(32'h7F800000, 32'hFF800000, 2'b00, 1'b0, "R10 opposite infinities");
        apply(32'h7F800000, 32'h7F800000, 2'b00, 1'b0, "R4 same infinities");
        apply(32'hFF800000, 32'h40A00000, 2'b10, 1'b0, "R4 infinity plus finite");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b00, 1'b0, "R7 overflow nearest");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b01, 1'b0, "R7 overflow toward zero");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b11, 1'b0, "R7 overflow positive down");
        apply(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b11, 1'b0, "R7 overflow negative down");
        apply(32'h00000001, 32'h00000001, 2'b00, 1'b0, "R9 exact subnormal sum");
        apply(32'h007FFFFF, 32'h00000001, 2'b00, 1'b0, "R8 subnormal into normal");
        apply(32'h00000001, 32'h3F800000, 2'b00, 1'b1, "R8 flushed subnormal");
        apply(32'h00400000, 32'h80400000, 2'b11, 1'b1, "R8 flushed opposite zeros");
        apply(32'h00400000, 32'h00000003, 2'b00, 1'b1, "R8 both flushed");

        // R1: mid-run reset
        @(negedge clk);
        compare_pending();
        x_i = 32'h3F800000; y_i = 32'h3F800000; rst = 1'b1;
        pend_exp = '0; pend_tag = "R1 mid-run reset"; have_pend = 1'b1;
        @(negedge clk);
        compare_pending();
        rst = 1'b0;

        for (int n = 0; n < 4000; n++) begin
            a = pick(int'($urandom % 10), 32'h3F800000);
            b = pick(int'($urandom % 10), a);
            apply(a, b, 2'($urandom), 1'($urandom), "");
        end
        @(negedge clk);
        compare_pending();
        finish_run();
    end
endmodule